// File: doc/BRIEF.md
# Halt-Aware Free-Running Timer with Guarded Status Flags

This block holds a free-running up-counter and a small bank of per-channel status flags. Each flag has an interrupt enable, and the enabled flags together drive one interrupt request. Channel logic outside the block raises a flag with a one-cycle set strobe. Software clears a flag in two steps. First it reads the flag register while the flag is set, which arms that flag. Then it writes a 0 to that flag's bit, which clears it.

Three chip-level states gate the block. In the low-power wait state the counter keeps running and the interrupt stays live, but the register bus is ignored. In the deep-sleep stop state the counter is held and no register changes. While a debug halt is active the counter is frozen. A control bit, which is 0 after reset, then decides whether software can disturb the flags. When it is 0, a clear that was armed before the halt stays pending through the halt and can be finished afterwards.

The register bus is a plain single-cycle strobe interface with no back-pressure. A read or write is accepted in the cycle its strobe is high, and read data is combinational in that cycle. No data stream crosses the block, so there is no valid/ready handshake.

Top module: `tmr_top`

## Requirements
- R1: With stop and halt both low, `count` rises by exactly one per clock and wraps from all-ones to zero.
- R2: While `wait_mode` is high, the counter keeps advancing, flags still set from `ch_set`, and `irq` still follows the enabled flags.
- R3: While `wait_mode` is high, bus writes change no register, bus reads return 0, and reads do not arm a clear.
- R4: While `stop_mode` is high, `count` holds its value, `ch_set` strobes and bus accesses have no effect, and counting resumes from the held value once stop drops.
- R5: While `brk_active` is high, `count` holds its value.
- R6: The flag register is at address 0, with bit i for channel i. A read of address 0 that sees bit i set arms channel i. A later write to address 0 with bit i at 0 clears flag i. A 0-write to a flag that is not armed does not clear it, and writing a 1 never clears a flag.
- R7: While `brk_active` is high and the clear-permit bit is 0, writes to address 0 leave every flag unchanged and reads do not arm. A clear armed before the halt stays armed, and a 0-write after the halt completes it.
- R8: The clear-permit bit is bit 0 of address 2. When it is 1, the two-step clear works during the halt, and a flag cleared this way remains 0 after the halt ends.
- R9: If a set strobe arrives in the same cycle as a clearing write to that flag, the flag stays 1 and its armed state is dropped. A further 0-write without a new read then leaves it set.
- R10: The enable register is at address 1, with bit i for channel i. `irq` is high exactly when some flag and its enable bit are both 1.
- R11: Reset (`rst_n` low) gives count 0, all flags 0, all enables 0, nothing armed, and the clear-permit bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_mode | input | 1 | Low-power wait state, bus ignored |
| stop_mode | input | 1 | Deep-sleep state, everything held |
| brk_active | input | 1 | Debug halt active |
| ch_set | input | NCH | Per-channel one-cycle flag set strobes |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe, has priority over read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data |
| count | output | CNT_W | Free-running counter value |
| flags | output | NCH | Status flags |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same clock. A hardware set strobe can meet the clearing write of an armed flag. A debug halt can begin or end between the arming read and the clearing write. The bench provokes the first by driving `ch_set` in the very cycle of the 0-write. It then judges the result by checking that the flag is still high, and that a second 0-write without a fresh read also leaves it set. For the second, it arms one flag before the halt and reads another flag during the halt. After the halt a single 0-write must clear only the flag that was armed before the halt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_PERMIT_BIT = 0;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (run) count <= count + 1'b1;
  end
endmodule

// File: rtl/tmr_bus_gate.sv
module tmr_bus_gate
  import tmr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic           wait_mode,
  input  logic           stop_mode,
  input  logic           brk_active,
  input  logic           permit,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [NCH-1:0] flags,
  input  logic [NCH-1:0] en,
  output logic           arm_rd,
  output logic           clr_wr,
  output logic           en_we,
  output logic           ctrl_we,
  output logic [DW-1:0]  rdata
);
  logic     acc_ok, flag_sw_ok;
  reg_sel_e sel;

  assign sel        = reg_sel_e'(bus_addr);
  assign acc_ok     = !wait_mode && !stop_mode;
  assign flag_sw_ok = acc_ok && (!brk_active || permit);

  assign arm_rd  = bus_rd && !bus_wr && flag_sw_ok && (sel == SEL_FLAG);
  assign clr_wr  = bus_wr && flag_sw_ok && (sel == SEL_FLAG);
  assign en_we   = bus_wr && acc_ok && (sel == SEL_EN);
  assign ctrl_we = bus_wr && acc_ok && (sel == SEL_CTRL);

  always_comb begin
    rdata = '0;
    if (acc_ok) begin
      unique case (sel)
        SEL_FLAG: rdata[NCH-1:0] = flags;
        SEL_EN:   rdata[NCH-1:0] = en;
        SEL_CTRL: rdata[CTRL_PERMIT_BIT] = permit;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ok,
  input  logic arm_rd,
  input  logic clr_wr,
  input  logic wbit,
  output logic flag
);
  logic armed;
  logic clear_hit;

  assign clear_hit = clr_wr && !wbit && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (clear_hit) begin
      // a simultaneous set keeps the flag and drops the arm
      flag  <= set_ok;
      armed <= 1'b0;
    end else begin
      if (set_ok)          flag  <= 1'b1;
      if (arm_rd && flag)  armed <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_mode,
  input  logic             stop_mode,
  input  logic             brk_active,
  input  logic [NCH-1:0]   ch_set,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [CNT_W-1:0] count,
  output logic [NCH-1:0]   flags,
  output logic             irq
);
  logic           bce_q;
  logic [NCH-1:0] en_q;
  logic           arm_rd, clr_wr, en_we, ctrl_we;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!stop_mode && !brk_active),
    .count (count)
  );

  tmr_bus_gate #(.NCH(NCH), .DW(DW)) u_gate (
    .wait_mode  (wait_mode),
    .stop_mode  (stop_mode),
    .brk_active (brk_active),
    .permit     (bce_q),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .flags      (flags),
    .en         (en_q),
    .arm_rd     (arm_rd),
    .clr_wr     (clr_wr),
    .en_we      (en_we),
    .ctrl_we    (ctrl_we),
    .rdata      (bus_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ok (ch_set[i] && !stop_mode),
      .arm_rd (arm_rd),
      .clr_wr (clr_wr),
      .wbit   (bus_wdata[i]),
      .flag   (flags[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      bce_q <= 1'b0;
    end else begin
      if (en_we)   en_q  <= bus_wdata[NCH-1:0];
      if (ctrl_we) bce_q <= bus_wdata[CTRL_PERMIT_BIT];
    end
  end

  assign irq = |(flags & en_q);
endmodule

// File: rtl/tmr_top_chk.sv
module tmr_top_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wait_mode,
  input logic             stop_mode,
  input logic             brk_active,
  input logic             bce,
  input logic [NCH-1:0]   ch_set,
  input logic [CNT_W-1:0] count,
  input logic [NCH-1:0]   flags
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_mode && !brk_active) |=> ((count - $past(count)) == CNT_W'(1)));

  a_r4_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> $stable(count));

  a_r4_stop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> $stable(flags));

  a_r5_brk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |=> $stable(count));

  a_r3_wait_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wait_mode |=> ((~flags & $past(flags)) == '0));

  a_r7_brk_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && !bce) |=> ((~flags & $past(flags)) == '0));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_mode && (ch_set != '0)) |=> ((flags & $past(ch_set)) == $past(ch_set)));
endmodule

bind tmr_top tmr_top_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wait_mode  (wait_mode),
  .stop_mode  (stop_mode),
  .brk_active (brk_active),
  .bce        (bce_q),
  .ch_set     (ch_set),
  .count      (count),
  .flags      (flags)
);

// File: tb/tmr_top_bench.sv
module tmr_top_bench;
  localparam int CNT_W = 8;
  localparam int NCH   = 4;
  localparam int DW    = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic wait_m = 0, stop_m = 0, brk = 0;
  logic [NCH-1:0] ch_set = '0;
  logic b_rd = 0, b_wr = 0;
  logic [1:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic [DW-1:0] b_rdata;
  logic [CNT_W-1:0] count;
  logic [NCH-1:0] flags;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tmr_top #(.CNT_W(CNT_W), .NCH(NCH), .DW(DW)) u_tmr_top (
    .clk(clk), .rst_n(rst_n), .wait_mode(wait_m), .stop_mode(stop_m),
    .brk_active(brk), .ch_set(ch_set), .bus_rd(b_rd), .bus_wr(b_wr),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata),
    .count(count), .flags(flags), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d, input logic [NCH-1:0] s);
    @(negedge clk);
    b_wr = 1; b_addr = a; b_wdata = d; ch_set = s;
    @(negedge clk);
    b_wr = 0; ch_set = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    b_rd = 1; b_addr = a;
    #1 d = b_rdata;
    @(negedge clk);
    b_rd = 0;
  endtask

  task automatic pulse(input logic [NCH-1:0] s);
    @(negedge clk);
    ch_set = s;
    @(negedge clk);
    ch_set = '0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    @(negedge clk);
    check("R11 count", count, 0);
    check("R11 flags", flags, 0);
    check("R11 irq", irq, 0);
    rst_n = 1;
    rd_reg(2'd2, d);
    check("R11 permit", d, 0);
    rd_reg(2'd1, d);
    check("R11 enables", d, 0);
  endtask

  task automatic t_count();
    logic [CNT_W-1:0] c0;
    @(negedge clk);
    c0 = count;
    @(negedge clk);
    check("R1 step", count, c0 + 1'b1);
    for (int i = 0; i < 300 && count != {CNT_W{1'b1}}; i++) @(negedge clk);
    check("R1 at max", count, {CNT_W{1'b1}});
    @(negedge clk);
    check("R1 wrap", count, 0);
  endtask

  task automatic t_wait();
    logic [CNT_W-1:0] c0;
    logic [DW-1:0] d;
    wr_reg(2'd1, 8'h01, '0);
    wait_m = 1;
    c0 = count;
    @(negedge clk);
    check("R2 count in wait", count, c0 + 1'b1);
    pulse(4'b0001);
    check("R2 flag set in wait", flags, 4'b0001);
    check("R2 irq in wait", irq, 1);
    wr_reg(2'd1, 8'h0F, '0);
    rd_reg(2'd0, d);
    check("R3 read in wait", d, 0);
    wr_reg(2'd0, 8'h00, '0);
    check("R3 no arm in wait", flags, 4'b0001);
    wait_m = 0;
    rd_reg(2'd1, d);
    check("R3 enable write ignored", d, 8'h01);
    wr_reg(2'd0, 8'h00, '0);
    check("R3 no arm left by wait read", flags, 4'b0001);
    rd_reg(2'd0, d);
    wr_reg(2'd0, 8'h00, '0);
    check("R6 cleanup clear", flags, 0);
  endtask

  task automatic t_stop();
    logic [CNT_W-1:0] c0;
    stop_m = 1;
    c0 = count;
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R4 count held", count, c0);
    pulse(4'b0100);
    check("R4 set ignored", flags, 0);
    wr_reg(2'd1, 8'h0F, '0);
    stop_m = 0;
    @(negedge clk);
    check("R4 resume", count, c0 + 1'b1);
    check("R4 enable write ignored", irq, 0);
  endtask

  task automatic t_two_step();
    logic [DW-1:0] d;
    pulse(4'b0010);
    check("R6 set", flags, 4'b0010);
    wr_reg(2'd0, 8'h00, '0);
    check("R6 unarmed write", flags, 4'b0010);
    rd_reg(2'd0, d);
    check("R6 read value", d, 8'h02);
    wr_reg(2'd0, 8'h02, '0);
    check("R6 write one keeps", flags, 4'b0010);
    wr_reg(2'd0, 8'h00, '0);
    check("R6 cleared", flags, 0);
  endtask

  task automatic t_brk_protect();
    logic [DW-1:0] d;
    logic [CNT_W-1:0] c0;
    pulse(4'b0100);
    rd_reg(2'd0, d);
    brk = 1;
    c0 = count;
    pulse(4'b1000);
    check("R5 count frozen", count, c0);
    wr_reg(2'd0, 8'h00, '0);
    check("R7 write blocked", flags, 4'b1100);
    rd_reg(2'd0, d);
    check("R7 read allowed", d, 8'h0C);
    @(negedge clk);
    check("R5 still frozen", count, c0);
    brk = 0;
    wr_reg(2'd0, 8'h00, '0);
    check("R7 pending clear done, halt read not armed", flags, 4'b1000);
  endtask

  task automatic t_brk_clear();
    logic [DW-1:0] d;
    wr_reg(2'd2, 8'h01, '0);
    brk = 1;
    rd_reg(2'd0, d);
    wr_reg(2'd0, 8'h00, '0);
    check("R8 cleared in halt", flags, 0);
    brk = 0;
    @(negedge clk);
    check("R8 stays cleared", flags, 0);
    wr_reg(2'd2, 8'h00, '0);
  endtask

  task automatic t_collision();
    logic [DW-1:0] d;
    pulse(4'b0001);
    rd_reg(2'd0, d);
    wr_reg(2'd0, 8'h00, 4'b0001);
    check("R9 set wins", flags, 4'b0001);
    wr_reg(2'd0, 8'h00, '0);
    check("R9 arm dropped", flags, 4'b0001);
  endtask

  task automatic t_irq();
    logic [DW-1:0] d;
    wr_reg(2'd1, 8'h00, '0);
    check("R10 masked", irq, 0);
    wr_reg(2'd1, 8'h01, '0);
    check("R10 enabled", irq, 1);
    wr_reg(2'd1, 8'h0E, '0);
    check("R10 other enables", irq, 0);
    wr_reg(2'd1, 8'h01, '0);
    rd_reg(2'd0, d);
    wr_reg(2'd0, 8'h00, '0);
    check("R10 cleared flag", irq, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_wait();
    t_stop();
    t_two_step();
    t_brk_protect();
    t_brk_clear();
    t_collision();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule